// File: doc/BRIEF.md
# Flash Write-Cycle Sequencer

This host-side controller drives an asynchronous parallel flash bus with a 16-bit address, a 16-bit data bus and active-low chip-enable, output-enable and write-enable strobes. One request starts a word program, a main-array erase or a whole-chip erase. For each one the block emits the unlock command prefix as a series of write cycles, then polls the flash with repeated reads until the operation has finished, and ends with a one-cycle done pulse.

All strobe widths are set in nanoseconds by parameters and turned into clock-cycle counts, rounded up, using the clock period parameter. Completion can be detected in two ways. One compares bit 6 of two reads in a row. The other compares bit 7 of a read with the value that was written. A programmable limit on the number of reads ends a stalled operation with an error. Normal data reads and the tristate pads are left to the surrounding logic. The block only says when it drives the data bus.

Top module: `flash_wr_seq`

## Requirements
- R1: A request (`req_i` high) is taken only while `busy_o` is low and `op_i` is not 2'b11. Requests made while busy, and opcode 2'b11, cause no bus cycle and no done pulse. `busy_o` goes low in the cycle after `done_o`.
- R2: Opcode 2'b00 (word program) makes exactly four write cycles, as (address, data): (5555h, 00AAh), (2AAAh, 0055h), (5555h, 00A0h), then (target address, target data).
- R3: Opcode 2'b01 (main erase) and opcode 2'b10 (chip erase) each make six write cycles: (5555h,00AAh), (2AAAh,0055h), (5555h,0080h), (5555h,00AAh), (2AAAh,0055h), then (5555h,0030h) for main erase or (5555h,0010h) for chip erase.
- R4: Each write-enable low pulse lasts exactly ceil(WP_NS/CLK_PERIOD_NS) cycles. Write-enable stays high for at least ceil(WPH_NS/CLK_PERIOD_NS) cycles between pulses.
- R5: Address and write data hold steady for the whole write-enable low pulse, and the data bus is driven (`fl_dq_oe_o` high) throughout it.
- R6: Output-enable is high whenever write-enable is low. Chip-enable is low whenever either strobe is low.
- R7: Every polling read uses the target address and leaves the data bus undriven. Output-enable stays high for at least ceil(OEH_NS/CLK_PERIOD_NS) cycles between reads.
- R8: With `poll_mode_i` = 0 (toggle), the operation completes at the first read whose bit 6 equals bit 6 of the read just before it.
- R9: With `poll_mode_i` = 1 (data), the operation completes at the first read whose bit 7 equals bit 7 of the written data. For an erase that bit is 1.
- R10: If POLL_MAX reads go by without completion, the block stops polling and ends with `err_o` high during the done pulse.
- R11: `done_o` is high for exactly one cycle per accepted request, and `err_o` is high only while `done_o` is high.
- R12: During and after reset, all three strobes are high, the data bus is undriven, and `busy_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request |
| op_i | input | 2 | 00 program, 01 main erase, 10 chip erase |
| addr_i | input | 16 | Target word address |
| data_i | input | 16 | Word to program |
| poll_mode_i | input | 1 | 0 toggle-bit polling, 1 data-bit polling |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Poll limit exceeded, valid with done_o |
| fl_addr_o | output | 16 | Flash address bus |
| fl_dq_o | output | 16 | Flash write data |
| fl_dq_oe_o | output | 1 | Write data should be driven onto the bus |
| fl_dq_i | input | 16 | Flash read data |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_oe_no | output | 1 | Output enable, active low |
| fl_we_no | output | 1 | Write enable, active low |

## Verification
The bench uses a flash model that stays busy for a chosen number of reads, toggling bit 6 and returning the complement of bit 7 while busy. It covers a busy window of zero reads, final data whose bit 6 does or does not match the last toggled value, and busy windows longer than the poll limit. A design that compared bit 6 against the very first read alone, or that tested bit 7 against 0 for erases, would finish one read early or late, or would time out. A design that let a request in while busy would append extra write cycles or a second done pulse. Pulse-width counting is checked on each edge, so an off-by-one timer load shows up as a wrong write-enable low width.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG        = 2'b00,
    OP_MAIN_ERASE  = 2'b01,
    OP_CHIP_ERASE  = 2'b10,
    OP_NONE        = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_WR_LO, S_WR_HI, S_RD_LO, S_RD_HI, S_DONE
  } state_e;

  localparam int          STEP_W = 3;
  localparam logic [15:0] UNLK_A = 16'h5555;
  localparam logic [15:0] UNLK_B = 16'h2AAA;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  code;
    logic        use_tgt;
    logic        last;
  } cmd_t;

  function automatic int ns2cyc(int ns, int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic cmd_t cmd_lookup(op_e op, logic [STEP_W-1:0] step);
    cmd_t c;
    c = '{addr: UNLK_A, code: 8'h00, use_tgt: 1'b0, last: 1'b0};
    case (step)
      3'd0: c.code = 8'hAA;
      3'd1: begin c.addr = UNLK_B; c.code = 8'h55; end
      3'd2: c.code = (op == OP_PROG) ? 8'hA0 : 8'h80;
      3'd3: begin
        if (op == OP_PROG) begin c.use_tgt = 1'b1; c.last = 1'b1; end
        else c.code = 8'hAA;
      end
      3'd4: begin c.addr = UNLK_B; c.code = 8'h55; end
      default: begin
        c.code = (op == OP_MAIN_ERASE) ? 8'h30 : 8'h10;
        c.last = 1'b1;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fseq_cmd.sv
module fseq_cmd
  import flash_seq_pkg::*;
(
  input  op_e                op_i,
  input  logic [STEP_W-1:0]  step_i,
  input  logic [15:0]        tgt_addr_i,
  input  logic [15:0]        tgt_data_i,
  output logic [15:0]        addr_o,
  output logic [15:0]        data_o,
  output logic               last_o
);
  cmd_t c;
  always_comb begin
    c      = cmd_lookup(op_i, step_i);
    addr_o = c.use_tgt ? tgt_addr_i : c.addr;
    data_o = c.use_tgt ? tgt_data_i : {8'h00, c.code};
    last_o = c.last;
  end
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o); // R4
endmodule

// File: rtl/fseq_poll.sv
module fseq_poll #(
  parameter int POLL_MAX = 4096,
  localparam int CW = $clog2(POLL_MAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       smp_i,
  input  logic       mode_i,
  input  logic       exp7_i,
  input  logic [1:0] dq76_i,
  output logic       hit_o,
  output logic       last_o
);
  logic [CW-1:0] cnt_q;
  logic          prev6_q, prev_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; prev6_q <= 1'b0; prev_vld_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0; prev_vld_q <= 1'b0;
    end else if (smp_i) begin
      if (!last_o) cnt_q <= cnt_q + 1'b1;
      prev6_q    <= dq76_i[0];
      prev_vld_q <= 1'b1;
    end
  end

  // data mode: bit 7 against written value; toggle mode: bit 6 against previous read
  assign hit_o  = mode_i ? (dq76_i[1] == exp7_i) : (prev_vld_q && (dq76_i[0] == prev6_q));
  assign last_o = (cnt_q == CW'(POLL_MAX - 1));

  AST_POLL_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(POLL_MAX)); // R10
  AST_POLL_FIRST_NO_TOGGLE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !mode_i) |=> !hit_o); // R8
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
  import flash_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int WP_NS         = 70,
  parameter int WPH_NS        = 50,
  parameter int OEH_NS        = 150,
  parameter int RD_NS         = 55,
  parameter int POLL_MAX      = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [1:0]  op_i,
  input  logic [15:0] addr_i,
  input  logic [15:0] data_i,
  input  logic        poll_mode_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] fl_addr_o,
  output logic [15:0] fl_dq_o,
  output logic        fl_dq_oe_o,
  input  logic [15:0] fl_dq_i,
  output logic        fl_ce_no,
  output logic        fl_oe_no,
  output logic        fl_we_no
);
  localparam int WP_CYC  = ns2cyc(WP_NS,  CLK_PERIOD_NS);
  localparam int WPH_CYC = ns2cyc(WPH_NS, CLK_PERIOD_NS);
  localparam int OEH_CYC = ns2cyc(OEH_NS, CLK_PERIOD_NS);
  localparam int RD_CYC  = ns2cyc(RD_NS,  CLK_PERIOD_NS);
  localparam int TMAX_A  = (WP_CYC > WPH_CYC) ? WP_CYC : WPH_CYC;
  localparam int TMAX_B  = (OEH_CYC > RD_CYC) ? OEH_CYC : RD_CYC;
  localparam int TMAX    = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TW      = $clog2(TMAX + 1);
  localparam logic [TW-1:0] WP_LD  = TW'(WP_CYC - 1);
  localparam logic [TW-1:0] WPH_LD = TW'(WPH_CYC - 1);
  localparam logic [TW-1:0] OEH_LD = TW'(OEH_CYC - 1);
  localparam logic [TW-1:0] RD_LD  = TW'(RD_CYC - 1);

  state_e            state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  op_e               op_q;
  logic [15:0]       addr_q, data_q;
  logic              mode_q, err_q;
  logic              we_n_q, oe_n_q, ce_n_q;
  logic              accept, to_err;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              poll_clr, poll_smp, poll_hit, poll_last;
  logic [15:0]       cmd_addr, cmd_data;
  logic              cmd_last;
  logic              exp7;
  logic              dq_unused;

  assign dq_unused = ^{fl_dq_i[15:8], fl_dq_i[5:0]};

  fseq_cmd u_cmd (
    .op_i       (op_q),
    .step_i     (step_q),
    .tgt_addr_i (addr_q),
    .tgt_data_i (data_q),
    .addr_o     (cmd_addr),
    .data_o     (cmd_data),
    .last_o     (cmd_last)
  );

  fseq_timer #(.TW(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  assign exp7 = (op_q == OP_PROG) ? data_q[7] : 1'b1;

  fseq_poll #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .smp_i  (poll_smp),
    .mode_i (mode_q),
    .exp7_i (exp7),
    .dq76_i (fl_dq_i[7:6]),
    .hit_o  (poll_hit),
    .last_o (poll_last)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    accept   = 1'b0;
    to_err   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    poll_clr = 1'b0;
    poll_smp = 1'b0;
    case (state_q)
      S_IDLE: if (req_i && (op_i != OP_NONE)) begin
        accept  = 1'b1;
        step_d  = '0;
        state_d = S_SETUP;
      end
      S_SETUP: begin
        state_d  = S_WR_LO;
        tmr_load = 1'b1;
        tmr_val  = WP_LD;
      end
      S_WR_LO: if (tmr_zero) begin
        state_d  = S_WR_HI;
        tmr_load = 1'b1;
        tmr_val  = WPH_LD;
      end
      S_WR_HI: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (cmd_last) begin
          state_d  = S_RD_LO;
          tmr_val  = RD_LD;
          poll_clr = 1'b1;
        end else begin
          state_d  = S_SETUP;
          step_d   = step_q + 1'b1;
        end
      end
      S_RD_LO: if (tmr_zero) begin
        poll_smp = 1'b1;
        if (poll_hit) begin
          state_d = S_DONE;
        end else if (poll_last) begin
          state_d = S_DONE;
          to_err  = 1'b1;
        end else begin
          state_d  = S_RD_HI;
          tmr_load = 1'b1;
          tmr_val  = OEH_LD;
        end
      end
      S_RD_HI: if (tmr_zero) begin
        state_d  = S_RD_LO;
        tmr_load = 1'b1;
        tmr_val  = RD_LD;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      mode_q  <= 1'b0;
      err_q   <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      ce_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (accept) begin
        op_q   <= op_e'(op_i);
        addr_q <= addr_i;
        data_q <= data_i;
        mode_q <= poll_mode_i;
        err_q  <= 1'b0;
      end else if (to_err) begin
        err_q  <= 1'b1;
      end
      // strobes from flops so they never glitch
      we_n_q <= (state_d != S_WR_LO);
      oe_n_q <= (state_d != S_RD_LO);
      ce_n_q <= (state_d == S_IDLE) || (state_d == S_DONE);
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign err_o      = done_o && err_q;
  assign fl_we_no   = we_n_q;
  assign fl_oe_no   = oe_n_q;
  assign fl_ce_no   = ce_n_q;
  assign fl_dq_oe_o = (state_q == S_SETUP) || (state_q == S_WR_LO) || (state_q == S_WR_HI);
  assign fl_addr_o  = ((state_q == S_RD_LO) || (state_q == S_RD_HI)) ? addr_q : cmd_addr;
  assign fl_dq_o    = cmd_data;

  AST_OE_OFF_WHILE_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> fl_oe_no); // R6
  AST_CE_WHILE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no || !fl_oe_no) |-> !fl_ce_no); // R6
  AST_WR_BUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_addr_o) && $stable(fl_dq_o))); // R5
  AST_DQ_DRIVEN_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> fl_dq_oe_o); // R5
  AST_DQ_OFF_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> !fl_dq_oe_o); // R7
  AST_RD_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> (fl_addr_o == addr_q)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_ERR_ONLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R11
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R1
  AST_REQ_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> $stable(addr_q)); // R1
endmodule

// File: tb/flash_wr_seq_tb_top.sv
module flash_wr_seq_tb_top;
  localparam int CLK_NS   = 10;
  localparam int POLL_MAX = 16;
  localparam int WP_CYC   = 7;
  localparam int WPH_CYC  = 5;
  localparam int OEH_CYC  = 15;

  typedef struct packed {
    logic [1:0]  op;
    logic        mode;
    logic [7:0]  nbusy;
    logic [15:0] addr;
    logic [15:0] data;
  } vec_t;

  localparam vec_t VEC [0:6] = '{
    '{2'd0, 1'b0, 8'd3,  16'h1234, 16'h5A5A},
    '{2'd0, 1'b1, 8'd2,  16'h0040, 16'h0080},
    '{2'd1, 1'b0, 8'd4,  16'hABCD, 16'h0000},
    '{2'd2, 1'b1, 8'd0,  16'h0007, 16'h0000},
    '{2'd0, 1'b0, 8'd0,  16'hFFFE, 16'h0000},
    '{2'd1, 1'b1, 8'd40, 16'h2000, 16'h0000},
    '{2'd0, 1'b0, 8'd40, 16'h0100, 16'h1111}
  };

  logic clk = 0, rst_n = 0;
  logic req = 0, mode = 0;
  logic [1:0]  op = 0;
  logic [15:0] addr = 0, data = 0, fl_dq = 0;
  logic busy, done, err, dq_oe, ce_n, oe_n, we_n;
  logic [15:0] fl_addr, fl_dq_o;

  always #(CLK_NS/2) clk = ~clk;

  flash_wr_seq #(.CLK_PERIOD_NS(CLK_NS), .POLL_MAX(POLL_MAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .data_i(data), .poll_mode_i(mode), .busy_o(busy), .done_o(done), .err_o(err),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(dq_oe), .fl_dq_i(fl_dq),
    .fl_ce_no(ce_n), .fl_oe_no(oe_n), .fl_we_no(we_n)
  );

  int n_chk = 0, n_fail = 0;
  int cur_op, cur_n;
  logic [15:0] cur_a, cur_d;
  int wr_cnt, rd_cnt, done_cnt, lo_we, hi_we, hi_oe;
  int v_seq, v_wp, v_wgap, v_rgap, v_stab, v_ctl, v_raddr;
  bit had_wr, had_rd, prev_oe, err_seen;
  logic [15:0] cap_a, cap_d;

  task automatic chk(bit ok, string req_tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wr(int o, int k, logic [15:0] a, logic [15:0] d);
    case (k)
      0: return {16'h5555, 16'h00AA};
      1: return {16'h2AAA, 16'h0055};
      2: return (o == 0) ? {16'h5555, 16'h00A0} : {16'h5555, 16'h0080};
      3: return (o == 0) ? {a, d} : {16'h5555, 16'h00AA};
      4: return (o == 0) ? 32'hFFFF_FFFF : {16'h2AAA, 16'h0055};
      5: return (o == 1) ? {16'h5555, 16'h0030} :
                (o == 2) ? {16'h5555, 16'h0010} : 32'hFFFF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int need_reads(int o, bit m, int n, logic [15:0] d);
    bit t6;
    if (m) return n + 1;
    t6 = (o == 0) ? d[6] : 1'b1;
    if (n == 0) return 2;
    return (t6 == bit'((n - 1) & 1)) ? n + 1 : n + 2;
  endfunction

  // bus monitor and flash model, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin done_cnt++; if (err) err_seen = 1; end
      if (!we_n) begin
        if (!oe_n || ce_n || !dq_oe) v_ctl++;
        if (lo_we == 0) begin
          cap_a = fl_addr; cap_d = fl_dq_o;
          if (had_wr && hi_we < WPH_CYC) v_wgap++;
        end else if (fl_addr != cap_a || fl_dq_o != cap_d) v_stab++;
        lo_we++;
      end else begin
        if (lo_we != 0) begin
          if (lo_we != WP_CYC) v_wp++;
          if ({cap_a, cap_d} != exp_wr(cur_op, wr_cnt, cur_a, cur_d)) v_seq++;
          wr_cnt++; had_wr = 1; hi_we = 0; lo_we = 0;
        end
        hi_we++;
      end
      if (!oe_n) begin
        if (ce_n || dq_oe) v_ctl++;
        if (prev_oe) begin
          rd_cnt++;
          if (fl_addr != cur_a) v_raddr++;
          if (had_rd && hi_oe < OEH_CYC) v_rgap++;
          if (rd_cnt <= cur_n)
            fl_dq = {8'h00, ~((cur_op == 0) ? cur_d[7] : 1'b1), 1'(rd_cnt - 1), 6'h00};
          else
            fl_dq = (cur_op == 0) ? cur_d : 16'hFFFF;
        end
        prev_oe = 0;
      end else begin
        if (!prev_oe) begin had_rd = 1; hi_oe = 0; end
        hi_oe++;
        prev_oe = 1;
      end
    end
  end

  task automatic start_op(int o, bit m, int n, logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    cur_op = o; cur_n = n; cur_a = a; cur_d = d;
    wr_cnt = 0; rd_cnt = 0; done_cnt = 0; lo_we = 0; hi_we = 0; hi_oe = 0;
    v_seq = 0; v_wp = 0; v_wgap = 0; v_rgap = 0; v_stab = 0; v_ctl = 0; v_raddr = 0;
    had_wr = 0; had_rd = 0; prev_oe = 1; err_seen = 0;
    op = 2'(o); mode = m; addr = a; data = d; req = 1;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_op(int o, bit m, int n, logic [15:0] d);
    int need, exp_rd;
    bit exp_err;
    need    = need_reads(o, m, n, d);
    exp_err = need > POLL_MAX;
    exp_rd  = exp_err ? POLL_MAX : need;
    if (o == 0) begin
      chk(wr_cnt == 4, "R2", "program write count", wr_cnt, 4);
      chk(v_seq == 0, "R2", "program write sequence mismatches", v_seq, 0);
    end else begin
      chk(wr_cnt == 6, "R3", "erase write count", wr_cnt, 6);
      chk(v_seq == 0, "R3", "erase write sequence mismatches", v_seq, 0);
    end
    chk(v_wp == 0,    "R4", "write low width errors", v_wp, 0);
    chk(v_wgap == 0,  "R4", "write high gap errors", v_wgap, 0);
    chk(v_stab == 0,  "R5", "bus changes during write", v_stab, 0);
    chk(v_ctl == 0,   "R6", "strobe overlap errors", v_ctl, 0);
    chk(v_raddr == 0, "R7", "poll address errors", v_raddr, 0);
    chk(v_rgap == 0,  "R7", "read high gap errors", v_rgap, 0);
    if (exp_err)
      chk(rd_cnt == exp_rd, "R10", "reads before timeout", rd_cnt, exp_rd);
    else if (m)
      chk(rd_cnt == exp_rd, "R9", "data-poll reads", rd_cnt, exp_rd);
    else
      chk(rd_cnt == exp_rd, "R8", "toggle-poll reads", rd_cnt, exp_rd);
    chk(err_seen == exp_err, "R10", "error flag", int'(err_seen), int'(exp_err));
    chk(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
    chk(busy == 0, "R11", "busy after done", int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(we_n && oe_n && ce_n, "R12", "strobes high in reset", int'({we_n, oe_n, ce_n}), 7);
    chk(!dq_oe && !busy && !done && !err, "R12", "status low in reset",
        int'({dq_oe, busy, done, err}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(we_n && oe_n && ce_n && !busy, "R12", "idle after reset", int'({we_n, oe_n, ce_n, busy}), 14);

    foreach (VEC[i]) begin
      start_op(int'(VEC[i].op), VEC[i].mode, int'(VEC[i].nbusy), VEC[i].addr, VEC[i].data);
      wait_done();
      check_op(int'(VEC[i].op), VEC[i].mode, int'(VEC[i].nbusy), VEC[i].data);
    end

    // R1: request during busy has no effect
    start_op(0, 1'b0, 1, 16'h0F0F, 16'h0000);
    repeat (20) @(negedge clk);
    op = 2'd2; req = 1;
    @(negedge clk);
    req = 0;
    wait_done();
    check_op(0, 1'b0, 1, 16'h0000);
    repeat (40) @(negedge clk);
    chk(wr_cnt == 4 && done_cnt == 1, "R1", "writes after busy request", wr_cnt, 4);

    // R1: reserved opcode ignored
    start_op(3, 1'b0, 0, 16'h0001, 16'h0001);
    repeat (60) @(negedge clk);
    chk(!busy && wr_cnt == 0 && rd_cnt == 0, "R1", "bus cycles for opcode 3", wr_cnt + rd_cnt, 0);
    chk(done_cnt == 0, "R1", "done pulses for opcode 3", done_cnt, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule